// File: doc/BRIEF.md
# Double-Buffered IN Endpoint Packet Buffer

This block sits between a byte producer (a DMA master or the processor) and the USB transmit engine of one IN endpoint. It holds two packet buffers of `DEPTH` bytes each and uses them in ping-pong fashion. The producer fills one buffer while the engine drains the other, so the bus side and the serial side overlap.

Once a buffer is committed, its length and bytes are offered on the transmit port. The engine pops bytes one at a time and pulses a done strobe when the packet has gone out. That strobe frees the buffer for new data. Two bits in a small configuration word switch on DMA pacing and choose which of two active-low request lines is driven.

In DMA mode, a buffer that reaches `DEPTH` bytes is committed on its own. A shorter last packet needs a software commit, normally issued from the DMA-complete handler. For example, a 150-byte transfer with 64-byte buffers produces two automatic 64-byte commits and then one software commit of 22 bytes.

Top module: `inep_dbuf`

## Requirements
- R1: Two buffers of DEPTH bytes each. `wr_ready` is high only while the buffer currently selected for writing is not committed and holds fewer than DEPTH bytes. A byte offered while `wr_ready` is low is dropped.
- R2: A pulse on `cfg_wr` loads `cfg_wdata`. Bit 0 enables DMA pacing and bit 1 selects the request line. Both read back on `cfg_rdata` bits 0 and 1. Bit 2 is a write-1 commit trigger that is never stored, and `cfg_rdata` bit 2 is always 0.
- R3: With DMA enabled, a byte write that brings the write buffer to DEPTH bytes commits that buffer at the same clock edge, and writing moves to the other buffer.
- R4: With DMA disabled, a full buffer stays uncommitted and `wr_ready` stays low until a software commit.
- R5: A configuration write with bit 2 set commits the write buffer with its current byte count, including a count of zero. If that buffer is already committed, the trigger is ignored.
- R6: Committed packets are offered in commit order, alternating between the two buffers. `tx_avail` is high and `tx_len` gives the packet length (0 when `tx_avail` is low). `tx_data` shows the byte at the current read index, and `tx_pop` advances that index up to the packet length.
- R7: `tx_done` while `tx_avail` is high frees the offered buffer, resets the read index and moves to the other buffer. `tx_done` while `tx_avail` is low has no effect.
- R8: While DMA is enabled and `wr_ready` is high, `dreq_n[sel]` is low, where `sel` is the request-select bit. The other line stays high. Both lines are high when DMA is off or the write buffer cannot take a byte.
- R9: A 150-byte DMA transfer with 64-byte buffers produces two automatic 64-byte commits. The 22 remaining bytes stay uncommitted until a software trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | {commit trigger, request select, DMA enable} |
| cfg_rdata | output | 3 | {0, request select, DMA enable} |
| wr_valid | input | 1 | Byte offered by the producer |
| wr_data | input | DW | Byte value |
| wr_ready | output | 1 | Write buffer can accept a byte |
| tx_avail | output | 1 | A committed packet is offered |
| tx_len | output | CW | Length of the offered packet |
| tx_data | output | DW | Byte at the read index |
| tx_pop | input | 1 | Advance the read index |
| tx_done | input | 1 | Offered packet sent, free its buffer |
| dreq_n | output | 2 | Active-low DMA request lines |

## Verification
The bench builds the block with its defaults, `DEPTH` = 64 and `DW` = 8. With these values the 150-byte transfer splits exactly into 64, 64 and 22 bytes, and the bench checks the full-buffer auto-commit boundary at the real packet size. A long random phase mixes byte writes, pops, done strobes, mode changes and triggers. That phase reaches the state where both buffers are committed and the producer stalls, zero-length commits, and done strobes that arrive in mid-packet or with nothing offered.

// File: rtl/inep_pkg.sv
`timescale 1ns/1ps
package inep_pkg;
  localparam int CFG_W        = 3;
  localparam int CFG_DMA_BIT  = 0;
  localparam int CFG_SEL_BIT  = 1;
  localparam int CFG_TRIG_BIT = 2;

  typedef enum logic {
    BUF_FILL = 1'b0,
    BUF_SEND = 1'b1
  } buf_state_e;
endpackage

// File: rtl/inep_buf.sv
`timescale 1ns/1ps
module inep_buf
  import inep_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  input  logic          rel,
  input  logic [CW-1:0] rd_idx,
  output buf_state_e    state,
  output logic [CW-1:0] count,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BUF_FILL;
      count <= '0;
    end else if (rel) begin
      state <= BUF_FILL;
      count <= '0;
    end else begin
      if (wr_en)  count <= count + CW'(1);
      if (commit) state <= BUF_SEND;
    end
  end

  assign rd_data = (rd_idx < CW'(DEPTH)) ? mem[rd_idx[AW-1:0]] : '0;

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r1_write_only_filling: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (state == BUF_FILL && count < CW'(DEPTH)));
  a_r7_release_only_sent: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> state == BUF_SEND);
  a_r5_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BUF_SEND && !rel) |=> (state == BUF_SEND && $stable(count)));
endmodule

// File: rtl/inep_ctrl.sv
`timescale 1ns/1ps
module inep_ctrl
  import inep_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                tx_pop,
  input  logic                tx_done,
  input  logic [1:0]          sent,
  input  logic [1:0][CW-1:0]  cnt,
  output logic [1:0]          wr_en,
  output logic [1:0]          commit,
  output logic [1:0]          rel,
  output logic [CW-1:0]       rd_idx,
  output logic                rsel,
  output logic                tx_avail,
  output logic [CW-1:0]       tx_len,
  output logic [1:0]          dreq_n
);
  function automatic logic reaches_full(input logic [CW-1:0] c);
    return c == CW'(DEPTH - 1);
  endfunction

  function automatic logic [1:0] req_lines(input logic act, input logic sel);
    logic [1:0] l;
    l = 2'b11;
    if (act) l[sel] = 1'b0;
    return l;
  endfunction

  logic          dma_en, req_sel, wsel;
  logic [CW-1:0] wcnt;
  logic          wfill, wr_fire, sw_trig, auto_fire, commit_fire;
  logic          done_fire, pop_fire;

  assign wcnt        = cnt[wsel];
  assign wfill       = !sent[wsel];
  assign wr_ready    = wfill && (wcnt < CW'(DEPTH));
  assign wr_fire     = wr_valid && wr_ready;
  assign sw_trig     = cfg_wr && cfg_wdata[CFG_TRIG_BIT] && wfill;
  assign auto_fire   = dma_en && wr_fire && reaches_full(wcnt);
  assign commit_fire = sw_trig || auto_fire;

  assign tx_avail  = sent[rsel];
  assign tx_len    = tx_avail ? cnt[rsel] : '0;
  assign done_fire = tx_done && tx_avail;
  assign pop_fire  = tx_pop && tx_avail && (rd_idx < tx_len) && !done_fire;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign wr_en[g]  = wr_fire     && (wsel == 1'(g));
    assign commit[g] = commit_fire && (wsel == 1'(g));
    assign rel[g]    = done_fire   && (rsel == 1'(g));
  end

  assign dreq_n    = req_lines(dma_en && wr_ready, req_sel);
  assign cfg_rdata = {1'b0, req_sel, dma_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en  <= 1'b0;
      req_sel <= 1'b0;
      wsel    <= 1'b0;
      rsel    <= 1'b0;
      rd_idx  <= '0;
    end else begin
      if (cfg_wr) begin
        dma_en  <= cfg_wdata[CFG_DMA_BIT];
        req_sel <= cfg_wdata[CFG_SEL_BIT];
      end
      if (commit_fire) wsel <= !wsel;
      if (done_fire) begin
        rsel   <= !rsel;
        rd_idx <= '0;
      end else if (pop_fire) begin
        rd_idx <= rd_idx + CW'(1);
      end
    end
  end

  a_r3_auto_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && wr_fire && wcnt == CW'(DEPTH - 1)) |=> sent[$past(wsel)]);
  a_r4_no_commit_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !(cfg_wr && cfg_wdata[CFG_TRIG_BIT])) |=> wsel == $past(wsel));
  a_r7_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> !sent[$past(rsel)]);
  a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_avail |-> rd_idx <= tx_len);
  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dreq_n));
  a_r8_both_sent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sent == 2'b11) |-> (dreq_n == 2'b11 && !wr_ready));
endmodule

// File: rtl/inep_dbuf.sv
`timescale 1ns/1ps
module inep_dbuf
  import inep_pkg::*;
#(
  parameter  int DEPTH = 64,
  parameter  int DW    = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_ready,
  output logic             tx_avail,
  output logic [CW-1:0]    tx_len,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_pop,
  input  logic             tx_done,
  output logic [1:0]       dreq_n
);
  logic [1:0]          sent, wr_en, commit, rel;
  logic [1:0][CW-1:0]  cnt;
  logic [1:0][DW-1:0]  rdat;
  logic [CW-1:0]       rd_idx;
  logic                rsel;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    buf_state_e st;
    inep_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en[g]),
      .wr_data (wr_data),
      .commit  (commit[g]),
      .rel     (rel[g]),
      .rd_idx  (rd_idx),
      .state   (st),
      .count   (cnt[g]),
      .rd_data (rdat[g])
    );
    assign sent[g] = (st == BUF_SEND);
  end

  inep_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .tx_pop    (tx_pop),
    .tx_done   (tx_done),
    .sent      (sent),
    .cnt       (cnt),
    .wr_en     (wr_en),
    .commit    (commit),
    .rel       (rel),
    .rd_idx    (rd_idx),
    .rsel      (rsel),
    .tx_avail  (tx_avail),
    .tx_len    (tx_len),
    .dreq_n    (dreq_n)
  );

  assign tx_data = rdat[rsel];

  a_r6_commit_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit) && $onehot0(rel) && $onehot0(wr_en));
endmodule

// File: tb/tb_inep_dbuf.sv
`timescale 1ns/1ps
module tb_inep_dbuf;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0, cfg_rdata;
  logic wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0, tx_data;
  logic wr_ready, tx_avail, tx_pop = 1'b0, tx_done = 1'b0;
  logic [CW-1:0] tx_len;
  logic [1:0] dreq_n;

  always #4 clk = !clk;

  inep_dbuf #(.DEPTH(DEPTH), .DW(DW)) dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: committed packets as a length queue plus a flat byte queue.
  logic [DW-1:0] fillq[$];
  logic [DW-1:0] sentq[$];
  int lenq[$];
  int rdidx = 0;
  bit m_dma = 0, m_sel = 0;
  int nsent;
  bit filling, wfire, trig, autoc, dn, pp;

  always @(posedge clk) begin
    if (!rst_n) begin
      fillq.delete(); sentq.delete(); lenq.delete();
      rdidx = 0; m_dma = 0; m_sel = 0;
    end else begin
      nsent   = lenq.size();
      filling = nsent < 2;
      wfire   = wr_valid && filling && fillq.size() < DEPTH;
      trig    = cfg_wr && cfg_wdata[2] && filling;
      autoc   = m_dma && wfire && fillq.size() == DEPTH - 1;
      dn      = tx_done && nsent > 0;
      pp      = tx_pop && nsent > 0 && rdidx < lenq[0];
      if (dn) begin
        repeat (lenq[0]) void'(sentq.pop_front());
        void'(lenq.pop_front());
        rdidx = 0;
      end else if (pp) rdidx++;
      if (wfire) fillq.push_back(wr_data);
      if (trig || autoc) begin
        lenq.push_back(fillq.size());
        foreach (fillq[i]) sentq.push_back(fillq[i]);
        fillq.delete();
      end
      if (cfg_wr) begin m_dma = cfg_wdata[0]; m_sel = cfg_wdata[1]; end
    end
  end

  bit e_ready, e_act;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      e_ready = lenq.size() < 2 && fillq.size() < DEPTH;
      e_act   = m_dma && e_ready;
      chk("R1 wr_ready", int'(wr_ready), int'(e_ready));
      chk("R2 cfg_rdata", int'(cfg_rdata), int'({1'b0, m_sel, m_dma}));
      chk("R6 tx_avail", int'(tx_avail), int'(lenq.size() > 0));
      chk("R6 tx_len", int'(tx_len), lenq.size() > 0 ? lenq[0] : 0);
      if (lenq.size() > 0 && rdidx < lenq[0])
        chk("R6 tx_data", int'(tx_data), int'(sentq[rdidx]));
      chk("R8 dreq_n", int'(dreq_n),
          int'({!(e_act && m_sel), !(e_act && !m_sel)}));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    cfg_wr = 0; cfg_wdata = '0; wr_valid = 0; tx_pop = 0; tx_done = 0;
  endtask

  task automatic cfg(input logic [2:0] v);
    tick(); cfg_wr = 1; cfg_wdata = v; tick();
  endtask

  task automatic put(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      tick(); wr_valid = 1; wr_data = DW'(base + i);
    end
    tick();
  endtask

  task automatic drain();
    int len;
    len = int'(tx_len);
    for (int i = 0; i < len; i++) begin tick(); tx_pop = 1; end
    tick(); tx_done = 1; tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    chk("R1 reset wr_ready", int'(wr_ready), 1);
    chk("R6 reset tx_avail", int'(tx_avail), 0);
    chk("R8 reset dreq_n", int'(dreq_n), 3);
    chk("R2 reset cfg_rdata", int'(cfg_rdata), 0);

    // 150 bytes by DMA on request line 0
    cfg(3'b001);
    chk("R8 line0 requested", int'(dreq_n), 2);
    put(64, 0);
    chk("R3 auto commit avail", int'(tx_avail), 1);
    chk("R3 auto commit len", int'(tx_len), 64);
    chk("R3 next buffer writable", int'(wr_ready), 1);
    put(64, 64);
    chk("R8 both committed no request", int'(dreq_n), 3);
    chk("R1 both committed not ready", int'(wr_ready), 0);
    drain();
    put(22, 128);
    chk("R9 second packet len", int'(tx_len), 64);
    drain();
    chk("R9 short packet not auto", int'(tx_avail), 0);
    cfg(3'b101);
    chk("R9 software commit len", int'(tx_len), 22);
    chk("R2 trigger reads zero", int'(cfg_rdata), 1);
    drain();

    // No DMA: full buffer waits for software, request line 1 selected
    cfg(3'b010);
    put(65, 7);
    chk("R4 full buffer uncommitted", int'(tx_avail), 0);
    chk("R4 full buffer not ready", int'(wr_ready), 0);
    chk("R8 dma off no request", int'(dreq_n), 3);
    cfg(3'b110);
    chk("R5 software commit full", int'(tx_len), 64);
    drain();

    // Zero-length commits, ignored third trigger, stray done
    tick(); tx_done = 1; tick();
    chk("R7 stray done ignored", int'(tx_avail), 0);
    cfg(3'b100); cfg(3'b100); cfg(3'b100);
    chk("R5 zero length", int'(tx_len), 0);
    chk("R5 both committed", int'(wr_ready), 0);
    drain(); drain();
    chk("R5 third trigger ignored", int'(tx_avail), 0);
    cfg(3'b011);
    chk("R8 line1 requested", int'(dreq_n), 1);

    // Random mix
    for (int c = 0; c < 6000; c++) begin
      tick();
      wr_valid = ($urandom % 4) != 0;
      wr_data  = DW'($urandom);
      tx_pop   = ($urandom % 3) != 0;
      tx_done  = ($urandom % 40) == 0;
      if (($urandom % 60) == 0) begin
        cfg_wr = 1; cfg_wdata = 3'($urandom);
      end
    end
    tick(); tick();
    finished = 1;
    summary();
  end
endmodule